// File: doc/BRIEF.md
# Indirect Register Address Mapper

This block sits between a small processor core and its register file. For every register-file access it forms the physical address and the read and write enables, and it hands the read data back to the core. A direct access takes its in-bank offset from the instruction word and its bank from a bank-select field. One in-bank offset, zero, names a virtual register that holds no storage. An access to it is redirected to the register whose address sits in a pointer register, extended by a separate indirect bank bit. Stepping the pointer walks the indirect access across consecutive registers.

When the pointer itself names the virtual register, the access would loop back onto itself. Such a read returns zero and leaves the register file untouched. Such a write is dropped, so the register file sees no write enable. The core's own flag logic may still act on the operation. The mapping is purely combinational, so the read data is valid in the same cycle as the address. The register storage and the flag logic are outside this block.

Top module: `regfile_addr_mapper`

## Requirements
- R1: When the direct offset `dir_addr` is nonzero, `eff_addr` equals `{bank_sel, dir_addr}` (bank in bits 8:7, offset in bits 6:0).
- R2: When `dir_addr` is zero, in any bank, the access is indirect and `eff_addr` equals `{ind_bank, ptr_reg}` (bank bit in bit 8, pointer in bits 7:0).
- R3: An indirect read whose pointer has zero in bits 6:0 (pointer 00h or 80h, with either bank bit) drives `core_rdata` to 00h and holds `rf_rd_en` low.
- R4: An indirect write whose pointer has zero in bits 6:0 holds `rf_wr_en` low.
- R5: For any other access, `rf_rd_en` follows `rd_stb` and `core_rdata` equals `rf_rdata` in the same cycle. Without `rd_stb`, `core_rdata` is 00h and `rf_rd_en` is low.
- R6: For any other access, `rf_wr_en` follows `wr_stb`, and `rf_wdata` always carries `wr_data`.
- R7: Incrementing `ptr_reg` by one moves the indirect access to the next register address, so the read data follows the contents of consecutive registers.
- R8: The indirect bank bit selects the upper half of the address space: pointer 05h with `ind_bank`=1 addresses 105h.
- R9: When read and write strobes arrive in the same cycle, both enables pass together for a normal target and both are suppressed together for a self-referencing target. The read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_addr | input | 7 | In-bank register offset taken from the instruction |
| bank_sel | input | 2 | Bank select for direct accesses |
| ptr_reg | input | 8 | Pointer register contents for indirect accesses |
| ind_bank | input | 1 | Bank bit placed above the pointer for indirect accesses |
| rd_stb | input | 1 | Core requests a register read this cycle |
| wr_stb | input | 1 | Core requests a register write this cycle |
| wr_data | input | 8 | Data the core writes |
| rf_rdata | input | 8 | Data the register file returns at `eff_addr` |
| eff_addr | output | 9 | Physical register-file address |
| rf_rd_en | output | 1 | Read enable to the register file |
| rf_wr_en | output | 1 | Write enable to the register file |
| rf_wdata | output | 8 | Write data to the register file |
| core_rdata | output | 8 | Read data returned to the core |

## Verification
A read and a write can reach the block in the same cycle, either on a pointer that names a real register or on one that names the virtual register. The bench drives both strobes together on pointer 41h and on pointer 00h with the bank bit set. For the real target it expects both enables high and the old contents on the read path, and a following read must return the new byte. For the self-referencing target it expects both enables low and zero read data. A bench register model that only updates on the write enable shows any write that leaked through.

// File: rtl/ram_map_pkg.sv
// Package: shared access classification for the register address mapper.
// Assumes: consumers use the enum only to steer combinational selection.
package ram_map_pkg;

    // Kind of register-file access after decoding the direct offset and pointer.
    typedef enum logic [1:0] {
        ACC_DIRECT   = 2'd0,
        ACC_INDIRECT = 2'd1,
        ACC_SELF     = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/ram_map_classify.sv
// Module: decides whether an access is direct, indirect, or indirect onto
// the virtual register itself.
// Assumes: offset zero in any bank is the virtual register; the pointer's
// low DIR_W bits identify the in-bank offset of the indirect target.
module ram_map_classify
    import ram_map_pkg::*;
#(
    parameter int DIR_W = 7
) (
    input  logic [DIR_W-1:0] dir_addr,
    input  logic [DIR_W-1:0] ptr_low,
    output acc_kind_e        kind
);

    logic virt_hit;
    logic ptr_self;

    assign virt_hit = (dir_addr == '0);
    assign ptr_self = (ptr_low == '0);

    // Pick the access kind from the two zero-offset detections.
    always_comb begin
        if (!virt_hit) begin
            kind = ACC_DIRECT;
        end else if (ptr_self) begin
            kind = ACC_SELF;
        end else begin
            kind = ACC_INDIRECT;
        end
    end

endmodule

// File: rtl/ram_map_addr.sv
// Module: forms the physical register-file address for the selected kind.
// Assumes: BANK_W + DIR_W == PTR_W + 1, so both forms fill the same width.
module ram_map_addr
    import ram_map_pkg::*;
#(
    parameter int DIR_W  = 7,
    parameter int BANK_W = 2,
    parameter int PTR_W  = 8,
    localparam int ADDR_W = BANK_W + DIR_W
) (
    input  acc_kind_e         kind,
    input  logic [DIR_W-1:0]  dir_addr,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [PTR_W-1:0]  ptr_reg,
    input  logic              ind_bank,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [ADDR_W-1:0] direct_addr;
    logic [ADDR_W-1:0] pointer_addr;

    assign direct_addr  = {bank_sel, dir_addr};
    assign pointer_addr = {ind_bank, ptr_reg};

    // Route the direct or pointer-derived address to the register file.
    always_comb begin
        unique case (kind)
            ACC_DIRECT: eff_addr = direct_addr;
            default:    eff_addr = pointer_addr;
        endcase
    end

endmodule

// File: rtl/ram_map_gate.sv
// Module: gates the read/write enables and returns read data to the core.
// Assumes: a self-referencing access must neither read nor write storage.
module ram_map_gate
    import ram_map_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  acc_kind_e         kind,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_rd_en,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [DATA_W-1:0] core_rdata
);

    logic allow;

    assign allow    = (kind != ACC_SELF);
    assign rf_wdata = wr_data;

    // Pass strobes through only for accesses that land on real storage.
    always_comb begin
        rf_rd_en = rd_stb && allow;
        rf_wr_en = wr_stb && allow;
    end

    // Return register data on an enabled read, zero otherwise, bit by bit.
    for (genvar b = 0; b < DATA_W; b++) begin : g_rbit
        assign core_rdata[b] = rf_rd_en & rf_rdata[b];
    end

endmodule

// File: rtl/regfile_addr_mapper.sv
// Module: top of the register address mapper. Converts direct and indirect
// register accesses into a physical address plus gated enables.
// Assumes: purely combinational; the register file answers rf_rdata for
// eff_addr within the same cycle.
module regfile_addr_mapper
    import ram_map_pkg::*;
#(
    parameter int DIR_W  = 7,
    parameter int BANK_W = 2,
    parameter int PTR_W  = 8,
    parameter int DATA_W = 8,
    localparam int ADDR_W = BANK_W + DIR_W
) (
    input  logic [DIR_W-1:0]  dir_addr,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [PTR_W-1:0]  ptr_reg,
    input  logic              ind_bank,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              rf_rd_en,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [DATA_W-1:0] core_rdata
);

    // Both address forms must fill the same physical width.
    if (PTR_W + 1 != ADDR_W) begin : g_width_bad
        $error("pointer plus bank bit must match bank plus offset width");
    end

    acc_kind_e kind;

    ram_map_classify #(
        .DIR_W (DIR_W)
    ) u_classify (
        .dir_addr (dir_addr),
        .ptr_low  (ptr_reg[DIR_W-1:0]),
        .kind     (kind)
    );

    ram_map_addr #(
        .DIR_W  (DIR_W),
        .BANK_W (BANK_W),
        .PTR_W  (PTR_W)
    ) u_addr (
        .kind     (kind),
        .dir_addr (dir_addr),
        .bank_sel (bank_sel),
        .ptr_reg  (ptr_reg),
        .ind_bank (ind_bank),
        .eff_addr (eff_addr)
    );

    ram_map_gate #(
        .DATA_W (DATA_W)
    ) u_gate (
        .kind       (kind),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .rf_rdata   (rf_rdata),
        .rf_rd_en   (rf_rd_en),
        .rf_wr_en   (rf_wr_en),
        .rf_wdata   (rf_wdata),
        .core_rdata (core_rdata)
    );

endmodule

// Checker: port-level rules of the mapper, evaluated whenever inputs settle.
// Assumes: inputs may be unknown before the driver starts; checks wait for
// known values.
module regfile_addr_mapper_chk #(
    parameter int DIR_W  = 7,
    parameter int BANK_W = 2,
    parameter int PTR_W  = 8,
    parameter int DATA_W = 8,
    localparam int ADDR_W = BANK_W + DIR_W
) (
    input logic [DIR_W-1:0]  dir_addr,
    input logic [BANK_W-1:0] bank_sel,
    input logic [PTR_W-1:0]  ptr_reg,
    input logic              ind_bank,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rf_rdata,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              rf_rd_en,
    input logic              rf_wr_en,
    input logic [DATA_W-1:0] rf_wdata,
    input logic [DATA_W-1:0] core_rdata
);

    logic known;
    logic self_ref;

    assign known    = !$isunknown({dir_addr, bank_sel, ptr_reg, ind_bank,
                                   rd_stb, wr_stb, wr_data, rf_rdata});
    assign self_ref = (dir_addr == '0) && (ptr_reg[DIR_W-1:0] == '0);

    // Evaluate the mapping rules on every settled input combination.
    always_comb begin
        if (known) begin
            if (dir_addr != '0) begin
                AST_DIRECT_ADDR: assert (eff_addr == {bank_sel, dir_addr}) else $error("direct address"); // R1
            end
            if (dir_addr == '0) begin
                AST_INDIRECT_ADDR: assert (eff_addr == {ind_bank, ptr_reg}) else $error("indirect address"); // R2
            end
            if (self_ref && rd_stb) begin
                AST_SELF_RD_ZERO: assert (core_rdata == '0 && !rf_rd_en) else $error("self read"); // R3
            end
            if (self_ref && wr_stb) begin
                AST_SELF_WR_BLOCK: assert (!rf_wr_en) else $error("self write"); // R4
            end
            if (!self_ref) begin
                AST_RD_PASS: assert (rf_rd_en == rd_stb && core_rdata == (rd_stb ? rf_rdata : '0)) else $error("read pass"); // R5
                AST_WR_PASS: assert (rf_wr_en == wr_stb) else $error("write pass"); // R6
            end
            AST_NO_STRAY_WR: assert (!rf_wr_en || wr_stb) else $error("stray write"); // R6
            AST_WDATA_PASS: assert (rf_wdata == wr_data) else $error("write data"); // R6
        end
    end

endmodule

bind regfile_addr_mapper regfile_addr_mapper_chk #(
    .DIR_W  (DIR_W),
    .BANK_W (BANK_W),
    .PTR_W  (PTR_W),
    .DATA_W (DATA_W)
) u_chk (
    .dir_addr   (dir_addr),
    .bank_sel   (bank_sel),
    .ptr_reg    (ptr_reg),
    .ind_bank   (ind_bank),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .rf_rdata   (rf_rdata),
    .eff_addr   (eff_addr),
    .rf_rd_en   (rf_rd_en),
    .rf_wr_en   (rf_wr_en),
    .rf_wdata   (rf_wdata),
    .core_rdata (core_rdata)
);

// File: tb/tb_regfile_addr_mapper.sv
// Bench: scoreboard for the register address mapper. A driver task applies
// an access on the falling edge and queues the expected outputs; a monitor
// pops and compares on the rising edge. A bench register model answers reads
// and updates only on the design's write enable.
module tb_regfile_addr_mapper;

    logic       clk = 1'b0;
    logic [6:0] dir_addr = '0;
    logic [1:0] bank_sel = '0;
    logic [7:0] ptr_reg = '0;
    logic       ind_bank = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rf_rdata;
    logic [8:0] eff_addr;
    logic       rf_rd_en;
    logic       rf_wr_en;
    logic [7:0] rf_wdata;
    logic [7:0] core_rdata;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [7:0] mem     [0:511];
    logic [7:0] exp_mem [0:511];

    typedef struct {
        string      tag;
        logic [8:0] addr;
        logic       rd_en;
        logic       wr_en;
        logic [7:0] wdata;
        logic [7:0] rdata;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    regfile_addr_mapper dut (
        .dir_addr   (dir_addr),
        .bank_sel   (bank_sel),
        .ptr_reg    (ptr_reg),
        .ind_bank   (ind_bank),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .rf_rdata   (rf_rdata),
        .eff_addr   (eff_addr),
        .rf_rd_en   (rf_rd_en),
        .rf_wr_en   (rf_wr_en),
        .rf_wdata   (rf_wdata),
        .core_rdata (core_rdata)
    );

    // Register file model: answers the current address, writes on enable.
    assign rf_rdata = mem[eff_addr];
    always @(posedge clk) begin
        if (rf_wr_en) mem[eff_addr] <= rf_wdata;
    end

    // Driver: apply one access and queue what the requirements predict.
    task automatic apply(input string tag, input logic [1:0] bk, input logic [6:0] da,
                         input logic ib, input logic [7:0] pr, input logic rd,
                         input logic wr, input logic [7:0] wd);
        exp_t e;
        logic self_ref;
        @(negedge clk);
        bank_sel = bk; dir_addr = da; ind_bank = ib; ptr_reg = pr;
        rd_stb = rd; wr_stb = wr; wr_data = wd;
        self_ref = (da == 7'h00) && (pr[6:0] == 7'h00);
        e.tag   = tag;
        e.addr  = (da != 7'h00) ? {bk, da} : {ib, pr};
        e.rd_en = rd && !self_ref;
        e.wr_en = wr && !self_ref;
        e.wdata = wd;
        e.rdata = e.rd_en ? exp_mem[e.addr] : 8'h00;
        if (e.wr_en) exp_mem[e.addr] = wd;
        sb.push_back(e);
    endtask

    // Monitor: compare settled outputs against the oldest queued item.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (eff_addr !== e.addr || rf_rd_en !== e.rd_en || rf_wr_en !== e.wr_en ||
                rf_wdata !== e.wdata || core_rdata !== e.rdata) begin
                bad++;
                $display("FAIL %s: got addr=%h rd=%b wr=%b wd=%h rdata=%h, expected addr=%h rd=%b wr=%b wd=%h rdata=%h",
                         e.tag, eff_addr, rf_rd_en, rf_wr_en, rf_wdata, core_rdata,
                         e.addr, e.rd_en, e.wr_en, e.wdata, e.rdata);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        if (cycles > 5000) begin
            total++;
            bad++;
            $display("FAIL watchdog: got cycles=%0d, expected under 5000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i]     = 8'((i * 7 + 3) & 8'hff);
            exp_mem[i] = 8'((i * 7 + 3) & 8'hff);
        end
        mem[9'h005] = 8'h10; exp_mem[9'h005] = 8'h10;
        mem[9'h006] = 8'h0A; exp_mem[9'h006] = 8'h0A;
        mem[9'h105] = 8'h5A; exp_mem[9'h105] = 8'h5A;

        apply("R5 idle no strobes",        2'd1, 7'h25, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        apply("R1 R5 direct read bank0",   2'd0, 7'h05, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
        apply("R1 direct read bank2 top",  2'd2, 7'h7F, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00);
        apply("R6 direct write bank3",     2'd3, 7'h21, 1'b0, 8'h00, 1'b0, 1'b1, 8'h3C);
        apply("R6 direct readback bank3",  2'd3, 7'h21, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
        apply("R2 indirect read ptr 05",   2'd1, 7'h00, 1'b0, 8'h05, 1'b1, 1'b0, 8'h00);
        apply("R7 indirect read ptr 06",   2'd3, 7'h00, 1'b0, 8'h06, 1'b1, 1'b0, 8'h00);
        apply("R8 bank bit ptr 05 -> 105", 2'd0, 7'h00, 1'b1, 8'h05, 1'b1, 1'b0, 8'h00);
        apply("R2 indirect write ptr 30",  2'd2, 7'h00, 1'b0, 8'h30, 1'b0, 1'b1, 8'h77);
        apply("R2 direct read of 030",     2'd0, 7'h30, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
        apply("R3 self read ptr 00",       2'd0, 7'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
        apply("R3 self read ptr 80 bank1", 2'd1, 7'h00, 1'b1, 8'h80, 1'b1, 1'b0, 8'h00);
        apply("R4 self write ptr 00",      2'd0, 7'h00, 1'b0, 8'h00, 1'b0, 1'b1, 8'h99);
        apply("R4 self write ptr 80",      2'd2, 7'h00, 1'b0, 8'h80, 1'b0, 1'b1, 8'h55);
        apply("R9 both strobes self",      2'd1, 7'h00, 1'b1, 8'h00, 1'b1, 1'b1, 8'hAB);
        apply("R9 both strobes ptr 41",    2'd0, 7'h00, 1'b0, 8'h41, 1'b1, 1'b1, 8'hE1);
        apply("R9 readback after both",    2'd0, 7'h00, 1'b0, 8'h41, 1'b1, 1'b0, 8'h00);
        for (int p = 1; p < 16; p++) begin
            apply("R7 pointer sweep",      2'd2, 7'h00, 1'b1, 8'(p), 1'b1, 1'b0, 8'h00);
        end
        apply("R5 no read strobe indir",   2'd0, 7'h00, 1'b0, 8'h07, 1'b0, 1'b0, 8'h00);

        @(negedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule